// File: doc/BRIEF.md
# Balanced Serial Link Primary Request Controller

This block runs the initiating side of a balanced, point-to-point serial link that uses fixed-length frames, variable-length frames and a single-character acknowledge. It turns user service requests (link reset, user data transfer, status query) into control bytes and transmit commands for an external frame transmitter. It then waits for the matching answer from an external frame receiver, which hands over only frames that have already been checked.

The frame count bit gives duplicate suppression. A link reset pins the bit to a known start value, and every confirmed data transfer flips it. When no valid confirm arrives within a window counted in bit-time ticks, the same frame goes out again with an unchanged count bit. After a set number of repeats the service ends with a failure. Only one service is outstanding at a time. After its own reset the block first resets the link by itself, and no request is taken until that exchange is over.

Top module: `link_req_ctrl`

## Requirements
- R1: Every transmitted control byte carries the direction bit (parameter DIR_OUT, default 1) in bit 7, a 1 in bit 6 (initiator), the frame count bit in bit 5, the count-valid bit in bit 4 and the function code in bits 3:0.
- R2: req_kind 0 sends a link reset (code 0x0, fixed frame, count-valid 0, count bit 0). req_kind 1 sends user data (code 0x3, variable frame with tx_var=1, count-valid 1, tx_ptr/tx_len equal to the request's pointer and length). req_kind 2 sends a status query (code 0x9, fixed frame, count-valid 0, count bit 0). req_kind 3 is ignored and sends nothing.
- R3: After reset is released, the block sends a link reset (control byte 0xC0) with no request present. It holds req_ready low until that exchange ends, and its outcome is not reported on svc_done or svc_fail.
- R4: The first user-data frame after a confirmed link reset carries count bit 1. Each confirmed user-data service flips the bit for the next one. A status service or a failed service leaves it unchanged, and every retransmission repeats the exact control byte.
- R5: If no confirm arrives within TIMEOUT_BITS bit_tick pulses after a transmission, the frame is sent again. After REPEAT_MAX retransmissions (1+REPEAT_MAX frames in all) with no confirm, svc_fail pulses for one cycle and the block returns to idle.
- R6: A link reset or user-data service is confirmed by a received acknowledge (rx_is_ack=1). A status service is confirmed only by a fixed frame whose control byte has bit 6 = 0 and code 0xB, whatever bit 4 holds. svc_done pulses in the cycle after the confirm is received.
- R7: A received negative answer (bit 6 = 0, code 0x1), a confirm of the wrong kind, or any frame received while no answer is awaited has no effect; the timeout path decides.
- R8: A request is taken only while req_ready is high. A request offered while a service is running is dropped. svc_done and svc_fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User offers a service request |
| req_kind | input | 2 | 0 link reset, 1 user data, 2 status query, 3 none |
| req_ptr | input | PTR_W | Data pointer for a user-data request |
| req_len | input | LEN_W | Data length for a user-data request |
| req_ready | output | 1 | Block is idle and takes a request |
| bit_tick | input | 1 | One pulse per line bit time |
| rx_valid | input | 1 | A checked frame has been received |
| rx_is_ack | input | 1 | Received frame is the single-character acknowledge |
| rx_ctrl | input | 8 | Control byte of a received fixed frame |
| tx_start | output | 1 | One-cycle command to send a frame |
| tx_ctrl | output | 8 | Control byte of the frame to send |
| tx_var | output | 1 | 1 selects a variable-length frame |
| tx_ptr | output | PTR_W | Data pointer for the transmitter |
| tx_len | output | LEN_W | Data length for the transmitter |
| svc_done | output | 1 | One-cycle pulse: user service confirmed |
| svc_fail | output | 1 | One-cycle pulse: user service failed after repeats |

## Verification
The assertions check on every cycle that each transmitted control byte has the initiator bit and direction bit set, and that its count-valid bit agrees with the frame length. They also check that a retransmission repeats the previous byte exactly, that the repeat counter and timer stay within their limits, and that a negative answer is never taken as a confirm. Only the bench's scenarios can show the service-level behaviour: the alternation of the count bit across a series of confirmed and failed services, the spacing of retries in bit times, the number of frames sent before a failure, and the silent startup reset.

// File: rtl/link_req_pkg.sv
package link_req_pkg;

  typedef enum logic [1:0] {
    KIND_RESET  = 2'd0,
    KIND_UDAT   = 2'd1,
    KIND_STATUS = 2'd2,
    KIND_NONE   = 2'd3
  } svc_kind_e;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SEND = 2'd2,
    ST_WAIT = 2'd3
  } link_state_e;

  localparam logic [3:0] FC_RESET      = 4'h0;
  localparam logic [3:0] FC_UDAT       = 4'h3;
  localparam logic [3:0] FC_STATUS     = 4'h9;
  localparam logic [3:0] FC_RSP_STATUS = 4'hB;
  localparam logic [3:0] FC_NACK       = 4'h1;

  function automatic logic [3:0] code_of(input svc_kind_e k);
    case (k)
      KIND_UDAT:   return FC_UDAT;
      KIND_STATUS: return FC_STATUS;
      default:     return FC_RESET;
    endcase
  endfunction

  function automatic logic fcv_of(input svc_kind_e k);
    return (k == KIND_UDAT);
  endfunction

  function automatic logic [7:0] make_ctrl(input logic dir, input logic fcb,
                                           input logic fcv, input logic [3:0] code);
    return {dir, 1'b1, fcb, fcv, code};
  endfunction

endpackage

// File: rtl/ctrl_builder.sv
module ctrl_builder
  import link_req_pkg::*;
#(
  parameter logic DIR_OUT = 1'b1
) (
  input  svc_kind_e   kind,
  input  logic        fcb,
  output logic [7:0]  ctrl,
  output logic        is_var
);
  logic fcv_w;

  always_comb begin
    fcv_w  = fcv_of(kind);
    ctrl   = make_ctrl(DIR_OUT, fcb & fcv_w, fcv_w, code_of(kind));
    is_var = fcv_w;
  end
endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int LIMIT = 510,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end_w;

  assign at_end_w = (cnt_q == CNT_W'(LIMIT - 1));
  assign expire   = run && tick && at_end_w;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= at_end_w ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: the bit-time count never passes the window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LIMIT));
endmodule

// File: rtl/confirm_detect.sv
module confirm_detect
  import link_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       waiting,
  input  svc_kind_e  kind,
  input  logic       rx_valid,
  input  logic       rx_is_ack,
  input  logic [7:0] rx_ctrl,
  output logic       confirm,
  output logic       nack_seen
);
  logic from_secondary_w;
  logic status_rsp_w;

  always_comb begin
    from_secondary_w = !rx_is_ack && !rx_ctrl[6];
    status_rsp_w     = from_secondary_w && (rx_ctrl[3:0] == FC_RSP_STATUS);
    nack_seen        = rx_valid && from_secondary_w && (rx_ctrl[3:0] == FC_NACK);
    if (kind == KIND_STATUS) confirm = waiting && rx_valid && status_rsp_w;
    else                     confirm = waiting && rx_valid && rx_is_ack;
  end

  // R7: a negative answer never counts as a confirm
  p_nack_not_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |-> !confirm);

  // R7: nothing is confirmed outside the answer window
  p_idle_no_confirm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |-> !confirm);
endmodule

// File: rtl/link_req_ctrl.sv
module link_req_ctrl
  import link_req_pkg::*;
#(
  parameter int   TIMEOUT_BITS = 510,
  parameter int   REPEAT_MAX   = 3,
  parameter int   PTR_W        = 16,
  parameter int   LEN_W        = 8,
  parameter logic DIR_OUT      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic             bit_tick,
  input  logic             rx_valid,
  input  logic             rx_is_ack,
  input  logic [7:0]       rx_ctrl,
  output logic             tx_start,
  output logic [7:0]       tx_ctrl,
  output logic             tx_var,
  output logic [PTR_W-1:0] tx_ptr,
  output logic [LEN_W-1:0] tx_len,
  output logic             svc_done,
  output logic             svc_fail
);
  localparam int TRY_W = $clog2(REPEAT_MAX + 1);

  link_state_e      state_q;
  svc_kind_e        kind_q;
  svc_kind_e        req_kind_w;
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             fcb_cur_q, fcb_next_q, user_q, done_q, fail_q;
  logic [TRY_W-1:0] tries_q;
  logic [7:0]       last_ctrl_q;

  // named internal events
  logic in_send_w, in_wait_w, accept_w, confirm_w, nack_w, expire_w, limit_w, retry_w;
  logic [7:0] ctrl_w;
  logic       var_w;

  assign req_kind_w = svc_kind_e'(req_kind);
  assign in_send_w  = (state_q == ST_SEND);
  assign in_wait_w  = (state_q == ST_WAIT);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept_w   = req_ready && req_valid && (req_kind_w != KIND_NONE);
  assign limit_w    = (tries_q == TRY_W'(REPEAT_MAX));
  assign retry_w    = in_send_w && (tries_q != '0);

  ctrl_builder #(.DIR_OUT(DIR_OUT)) u_ctrl (
    .kind   (kind_q),
    .fcb    (fcb_cur_q),
    .ctrl   (ctrl_w),
    .is_var (var_w)
  );

  bit_timer #(.LIMIT(TIMEOUT_BITS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (in_send_w),
    .run    (in_wait_w),
    .tick   (bit_tick),
    .expire (expire_w)
  );

  confirm_detect u_conf (
    .clk       (clk),
    .rst_n     (rst_n),
    .waiting   (in_wait_w),
    .kind      (kind_q),
    .rx_valid  (rx_valid),
    .rx_is_ack (rx_is_ack),
    .rx_ctrl   (rx_ctrl),
    .confirm   (confirm_w),
    .nack_seen (nack_w)
  );

  assign tx_start = in_send_w;
  assign tx_ctrl  = ctrl_w;
  assign tx_var   = var_w;
  assign tx_ptr   = ptr_q;
  assign tx_len   = len_q;
  assign svc_done = done_q;
  assign svc_fail = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_BOOT;
      kind_q     <= KIND_RESET;
      ptr_q      <= '0;
      len_q      <= '0;
      fcb_cur_q  <= 1'b0;
      fcb_next_q <= 1'b0;
      user_q     <= 1'b0;
      tries_q    <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (state_q)
        ST_BOOT: state_q <= ST_SEND;
        ST_IDLE: begin
          if (accept_w) begin
            kind_q    <= req_kind_w;
            ptr_q     <= req_ptr;
            len_q     <= req_len;
            tries_q   <= '0;
            user_q    <= 1'b1;
            fcb_cur_q <= (req_kind_w == KIND_UDAT) ? fcb_next_q : 1'b0;
            state_q   <= ST_SEND;
          end
        end
        ST_SEND: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (confirm_w) begin
            state_q <= ST_IDLE;
            done_q  <= user_q;
            if (kind_q == KIND_RESET)     fcb_next_q <= 1'b1;
            else if (kind_q == KIND_UDAT) fcb_next_q <= ~fcb_cur_q;
          end else if (expire_w) begin
            if (limit_w) begin
              state_q <= ST_IDLE;
              fail_q  <= user_q;
            end else begin
              tries_q <= tries_q + 1'b1;
              state_q <= ST_SEND;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker-side copy of the last transmitted byte
  always_ff @(posedge clk) begin
    if (!rst_n)        last_ctrl_q <= 8'h00;
    else if (tx_start) last_ctrl_q <= tx_ctrl;
  end

  // R1: initiator and direction bits on every frame
  p_prm_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_ctrl[6] && (tx_ctrl[7] == DIR_OUT)));

  // R2: count-valid only on variable frames carrying user data
  p_fcv_var_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ((tx_ctrl[4] == tx_var) && (tx_var == (tx_ctrl[3:0] == FC_UDAT))));

  // R4: a retransmission repeats the previous control byte
  p_retry_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_w |-> (tx_ctrl == last_ctrl_q));

  // R5: the repeat counter stays within the limit
  p_tries_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= TRY_W'(REPEAT_MAX));

  // R5: failure only after all repeats were used
  p_fail_after_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_fail |-> limit_w);

  // R8: an accepted request is sent in the next cycle, once
  p_accept_sends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> tx_start);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R8: one outcome at a time
  p_single_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_done && svc_fail));
endmodule

// File: tb/test_link_req_ctrl.sv
module test_link_req_ctrl;
  localparam int TIMEOUT_BITS = 12;
  localparam int REPEAT_MAX   = 3;
  localparam int TICK_DIV     = 4;

  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] ptr;
    logic [7:0] len;
    logic       rsp_ack;
    logic [7:0] rsp_ctrl;
    logic [7:0] exp_ctrl;
    logic       exp_var;
  } vec_t;

  // service sequence after the startup link reset (count bit then 1)
  localparam vec_t TBL [8] = '{
    '{2'd1, 8'h10, 8'd5,  1'b1, 8'h00, 8'hF3, 1'b1},
    '{2'd1, 8'h22, 8'd9,  1'b1, 8'h00, 8'hD3, 1'b1},
    '{2'd2, 8'h00, 8'd0,  1'b0, 8'h0B, 8'hC9, 1'b0},
    '{2'd1, 8'h31, 8'd1,  1'b1, 8'h00, 8'hF3, 1'b1},
    '{2'd2, 8'h00, 8'd0,  1'b0, 8'h1B, 8'hC9, 1'b0},
    '{2'd0, 8'h00, 8'd0,  1'b1, 8'h00, 8'hC0, 1'b0},
    '{2'd1, 8'h4A, 8'd31, 1'b1, 8'h00, 8'hF3, 1'b1},
    '{2'd1, 8'hFE, 8'd2,  1'b1, 8'h00, 8'hD3, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_ptr = 8'h00;
  logic [7:0] req_len = 8'h00;
  logic       req_ready;
  logic       bit_tick = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_is_ack = 1'b0;
  logic [7:0] rx_ctrl = 8'h00;
  logic       tx_start;
  logic [7:0] tx_ctrl;
  logic       tx_var;
  logic [7:0] tx_ptr;
  logic [7:0] tx_len;
  logic       svc_done;
  logic       svc_fail;

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int tick_div = 0;
  int tx_count = 0;
  int last_cyc = 0;
  int gap = 0;
  logic [7:0] last_ctrl = 8'h00;
  logic       last_var = 1'b0;
  logic [7:0] last_ptr = 8'h00;
  logic [7:0] last_len = 8'h00;

  always #5 clk = ~clk;

  link_req_ctrl #(
    .TIMEOUT_BITS(TIMEOUT_BITS), .REPEAT_MAX(REPEAT_MAX),
    .PTR_W(8), .LEN_W(8), .DIR_OUT(1'b1)
  ) i_link_req_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_ptr(req_ptr), .req_len(req_len),
    .req_ready(req_ready), .bit_tick(bit_tick),
    .rx_valid(rx_valid), .rx_is_ack(rx_is_ack), .rx_ctrl(rx_ctrl),
    .tx_start(tx_start), .tx_ctrl(tx_ctrl), .tx_var(tx_var),
    .tx_ptr(tx_ptr), .tx_len(tx_len),
    .svc_done(svc_done), .svc_fail(svc_fail)
  );

  // bit-time tick every TICK_DIV cycles, changed away from the active edge
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % TICK_DIV;
    bit_tick = (tick_div == 0);
  end

  // transmit monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && tx_start) begin
      tx_count  <= tx_count + 1;
      last_ctrl <= tx_ctrl;
      last_var  <= tx_var;
      last_ptr  <= tx_ptr;
      last_len  <= tx_len;
      gap       <= cyc - last_cyc;
      last_cyc  <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] p, input logic [7:0] l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_ptr = p; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_tx(input int prev);
    int n = 0;
    while (tx_count == prev && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic reply(input logic is_ack, input logic [7:0] c);
    rx_valid = 1'b1; rx_is_ack = is_ack; rx_ctrl = c;
    @(negedge clk);
    rx_valid = 1'b0; rx_is_ack = 1'b0; rx_ctrl = 8'h00;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int prev;
    int seen_done;
    int n;
    // reset state
    repeat (3) @(negedge clk);
    chk(!tx_start && !svc_done && !svc_fail, "R3 quiet in reset", tx_start, 0);
    chk(!req_ready, "R3 not ready in reset", req_ready, 0);
    rst_n = 1'b1;

    // R3: startup link reset without a request
    wait_tx(0);
    chk(last_ctrl == 8'hC0, "R3 startup ctrl", last_ctrl, 8'hC0);
    chk(last_var == 1'b0, "R2 startup fixed frame", last_var, 0);
    chk(!req_ready, "R3 busy during startup", req_ready, 0);
    reply(1'b1, 8'h00);
    chk(!svc_done && !svc_fail, "R3 silent startup outcome", svc_done, 0);
    chk(req_ready, "R3 ready after startup", req_ready, 1);

    // R1 R2 R4 R6: vector table
    for (int i = 0; i < 8; i++) begin
      prev = tx_count;
      issue(TBL[i].kind, TBL[i].ptr, TBL[i].len);
      wait_tx(prev);
      chk(last_ctrl == TBL[i].exp_ctrl, "R1 R4 ctrl byte", last_ctrl, TBL[i].exp_ctrl);
      chk(last_var == TBL[i].exp_var, "R2 frame length kind", last_var, TBL[i].exp_var);
      if (TBL[i].exp_var) begin
        chk(last_ptr == TBL[i].ptr && last_len == TBL[i].len, "R2 data pointer",
            {last_ptr, last_len}, {TBL[i].ptr, TBL[i].len});
      end
      reply(TBL[i].rsp_ack, TBL[i].rsp_ctrl);
      chk(svc_done && !svc_fail, "R6 confirm gives done", svc_done, 1);
    end

    // R8: request while busy is dropped (count bit now 1)
    prev = tx_count;
    issue(2'd1, 8'h05, 8'd3);
    wait_tx(prev);
    chk(last_ctrl == 8'hF3, "R4 ctrl after table", last_ctrl, 8'hF3);
    req_valid = 1'b1; req_kind = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    reply(1'b1, 8'h00);
    chk(svc_done, "R8 busy service done", svc_done, 1);
    repeat (80) @(negedge clk);
    chk(tx_count == prev + 1, "R8 busy request dropped", tx_count - prev, 1);

    // R7: negative answer ignored, retry with same byte
    prev = tx_count;
    issue(2'd1, 8'h06, 8'd4);
    wait_tx(prev);
    reply(1'b0, 8'h01);
    chk(!svc_done && !svc_fail, "R7 nack no outcome", svc_done, 0);
    prev = tx_count;
    wait_tx(prev);
    chk(last_ctrl == 8'hD3, "R4 R7 retry same count bit", last_ctrl, 8'hD3);
    reply(1'b1, 8'h00);
    chk(svc_done, "R7 done after retry", svc_done, 1);

    // R6 R7: status query ignores acknowledge and initiator-marked reply
    prev = tx_count;
    issue(2'd2, 8'h00, 8'd0);
    wait_tx(prev);
    reply(1'b1, 8'h00);
    chk(!svc_done, "R6 ack does not confirm status", svc_done, 0);
    reply(1'b0, 8'h4B);
    chk(!svc_done, "R6 initiator reply ignored", svc_done, 0);
    prev = tx_count;
    wait_tx(prev);
    chk(last_ctrl == 8'hC9, "R6 status retransmitted", last_ctrl, 8'hC9);
    reply(1'b0, 8'h0B);
    chk(svc_done, "R6 status confirmed", svc_done, 1);

    // R5: no answer, repeats then failure (count bit 1)
    prev = tx_count;
    issue(2'd1, 8'h07, 8'd8);
    wait_tx(prev);
    wait_tx(prev + 1);
    chk(gap >= TIMEOUT_BITS * TICK_DIV - 2 && gap <= TIMEOUT_BITS * TICK_DIV + 1,
        "R5 retry spacing in bit times", gap, TIMEOUT_BITS * TICK_DIV);
    seen_done = 0;
    n = 0;
    while (!svc_fail && n < 2000) begin
      if (svc_done) seen_done = 1;
      chk(last_ctrl == 8'hF3, "R4 retries keep byte", last_ctrl, 8'hF3);
      @(negedge clk);
      n++;
    end
    chk(svc_fail == 1'b1, "R5 fail pulse", svc_fail, 1);
    chk(seen_done == 0, "R8 no done on failure", seen_done, 0);
    chk(tx_count - prev == REPEAT_MAX + 1, "R5 frame count", tx_count - prev, REPEAT_MAX + 1);
    @(negedge clk);
    chk(!svc_fail && req_ready, "R5 fail is one pulse", svc_fail, 0);

    // R4: failure leaves count bit unchanged
    prev = tx_count;
    issue(2'd1, 8'h08, 8'd1);
    wait_tx(prev);
    chk(last_ctrl == 8'hF3, "R4 count bit after failure", last_ctrl, 8'hF3);
    reply(1'b1, 8'h00);
    chk(svc_done, "R4 done after failure", svc_done, 1);

    // R2: kind 3 ignored
    prev = tx_count;
    issue(2'd3, 8'h00, 8'd0);
    repeat (10) @(negedge clk);
    chk(tx_count == prev && req_ready, "R2 kind 3 ignored", tx_count - prev, 0);

    // R7: frames while idle ignored
    reply(1'b1, 8'h00);
    chk(!svc_done && !svc_fail, "R7 idle ack ignored", svc_done, 0);
    reply(1'b0, 8'h0B);
    chk(!svc_done && tx_count == prev, "R7 idle frame ignored", svc_done, 0);

    summary();
    $finish;
  end
endmodule